// File: doc/BRIEF.md
# Command Source Selector with Test-Mode Tracking

This block sits between the command inputs of a calendar/clock core and the logic that carries out its commands. On each accepted strobe it works out which command applies. A 3-bit code arrives on dedicated pins, and a 4-bit code is held in a serial command register that an external shifter fills. A pin code of all ones is an escape: the serial register supplies the command instead, and the core runs in serial transfer mode. Any other pin code is passed on, widened with a zero in the top bit.

The block also records which path supplied the latest command. That record drives a year-enable flag. While the flag is low, two further outputs are high: one tells the calendar that February keeps 28 days unless day 29 is written explicitly, and the other holds the interval timer halted. A test mode is tracked across strobes. Only the escape pin code together with serial code 1111 enters it. The pin path and the serial path each have their own set of codes that leave it.

The serial register is never frozen by a hold-type command. Whenever chip select is active and the escape code is present, the serial contents are taken as they stand.

Top module: `cmd_mode_decoder`

## Requirements
- R1: A strobe is accepted on a clock edge where `strobe` is high, it was low at the previous edge, and `cs` is high. The outputs update at that edge, and `cmd_valid` is high for exactly the following cycle.
- R2: A strobe rising while `cs` is low produces no `cmd_valid`, and `cmd_out`, `year_en` and `test_mode` keep their values.
- R3: When `par_cmd` is 111 at an accepted strobe, `cmd_out` becomes `ser_cmd` unchanged, whatever command came before, including a hold code.
- R4: When `par_cmd` is between 000 and 110 at an accepted strobe, `cmd_out` becomes `{1'b0, par_cmd}`.
- R5: After each accepted strobe, `year_en` is 1 if `par_cmd` was 111 and 0 otherwise.
- R6: `test_mode` becomes 1 after an accepted strobe with `par_cmd` = 111 and `ser_cmd` = 1111.
- R7: `test_mode` becomes 0 after an accepted strobe with `par_cmd` between 000 and 110.
- R8: With `par_cmd` = 111, serial code 0000 or any code from 0100 to 1110 clears `test_mode`. Codes 0001 to 0011 leave `test_mode` unchanged.
- R9: `feb29_manual` and `timer_halt` are both high exactly when `year_en` is low.
- R10: After reset, `cmd_out` = 0000, `cmd_valid` = 0, `year_en` = 0, `test_mode` = 0, and `feb29_manual` = `timer_halt` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_cmd | input | 3 | Command code from the parallel pins |
| ser_cmd | input | 4 | Contents of the serial command register |
| strobe | input | 1 | Command strobe; its rising edge is used |
| cs | input | 1 | Chip select, active high |
| cmd_out | output | 4 | Effective command |
| cmd_valid | output | 1 | One-cycle pulse after an accepted strobe |
| year_en | output | 1 | Year function enabled (serial transfer mode) |
| test_mode | output | 1 | Test mode active |
| feb29_manual | output | 1 | February has 28 days unless day 29 is written explicitly |
| timer_halt | output | 1 | Interval timer held halted |

## Verification
The hardest states to reach are the ones inside test mode. Serial codes 0001 to 0011 must leave the mode untouched, while the neighbouring codes clear it. These states only exist after an entry strobe with the exact pair 111/1111, which uniform random stimulus rarely produces. The random stream therefore biases the pin code towards 111 and the serial code towards 1111. Directed sequences also enter test mode and then try each holding code, one exit code per path, and a strobe with chip select low.

// File: rtl/cmdmode_pkg.sv
package cmdmode_pkg;
  localparam int PAR_W_DEF       = 3;
  localparam int SER_W_DEF       = 4;
  localparam int SER_EXIT_LO_DEF = 4;

  typedef enum logic {SRC_PAR = 1'b0, SRC_SER = 1'b1} cmd_src_e;
  typedef enum logic [1:0] {TM_KEEP = 2'd0, TM_ENTER = 2'd1, TM_LEAVE = 2'd2} tm_act_e;
endpackage

// File: rtl/cmd_strobe_edge.sv
module cmd_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic cs,
  output logic take
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= strobe;
  end

  assign take = strobe & ~stb_q & cs;
endmodule

// File: rtl/cmd_source_mux.sv
module cmd_source_mux
  import cmdmode_pkg::*;
#(
  parameter int PAR_W       = PAR_W_DEF,
  parameter int SER_W       = SER_W_DEF,
  parameter int SER_EXIT_LO = SER_EXIT_LO_DEF
) (
  input  logic [PAR_W-1:0] par,
  input  logic [SER_W-1:0] ser,
  output logic [SER_W-1:0] eff,
  output cmd_src_e         src,
  output tm_act_e          tm_act
);
  localparam int EXT_W = SER_W - PAR_W;
  localparam logic [PAR_W-1:0] ESC_CODE = '1;
  localparam logic [SER_W-1:0] SER_ALL1 = '1;
  localparam logic [SER_W-1:0] SER_LO   = SER_W'(SER_EXIT_LO);

  logic [SER_W-1:0] par_wide;

  generate
    if (EXT_W > 0) begin : g_ext
      assign par_wide = {{EXT_W{1'b0}}, par};
    end else begin : g_same
      assign par_wide = SER_W'(par);
    end
  endgenerate

  always_comb begin
    if (par == ESC_CODE) begin
      src = SRC_SER;
      eff = ser;
      if (ser == SER_ALL1)
        tm_act = TM_ENTER;
      else if (ser == '0 || ser >= SER_LO)
        tm_act = TM_LEAVE;
      else
        tm_act = TM_KEEP;
    end else begin
      src    = SRC_PAR;
      eff    = par_wide;
      tm_act = TM_LEAVE;
    end
  end
endmodule

// File: rtl/cmd_state_regs.sv
module cmd_state_regs
  import cmdmode_pkg::*;
#(
  parameter int SER_W = SER_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [SER_W-1:0] eff,
  input  cmd_src_e         src,
  input  tm_act_e          tm_act,
  output logic [SER_W-1:0] cmd_q,
  output logic             valid_q,
  output logic             year_q,
  output logic             test_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      valid_q <= 1'b0;
      year_q  <= 1'b0;
      test_q  <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) begin
        cmd_q  <= eff;
        year_q <= (src == SRC_SER);
        case (tm_act)
          TM_ENTER: test_q <= 1'b1;
          TM_LEAVE: test_q <= 1'b0;
          default:  test_q <= test_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_mode_decoder.sv
module cmd_mode_decoder
  import cmdmode_pkg::*;
#(
  parameter int PAR_W       = PAR_W_DEF,
  parameter int SER_W       = SER_W_DEF,
  parameter int SER_EXIT_LO = SER_EXIT_LO_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAR_W-1:0] par_cmd,
  input  logic [SER_W-1:0] ser_cmd,
  input  logic             strobe,
  input  logic             cs,
  output logic [SER_W-1:0] cmd_out,
  output logic             cmd_valid,
  output logic             year_en,
  output logic             test_mode,
  output logic             feb29_manual,
  output logic             timer_halt
);
  logic             take;
  logic [SER_W-1:0] eff;
  cmd_src_e         src;
  tm_act_e          tm_act;

  cmd_strobe_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .cs     (cs),
    .take   (take)
  );

  cmd_source_mux #(
    .PAR_W       (PAR_W),
    .SER_W       (SER_W),
    .SER_EXIT_LO (SER_EXIT_LO)
  ) u_mux (
    .par    (par_cmd),
    .ser    (ser_cmd),
    .eff    (eff),
    .src    (src),
    .tm_act (tm_act)
  );

  cmd_state_regs #(.SER_W(SER_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .eff     (eff),
    .src     (src),
    .tm_act  (tm_act),
    .cmd_q   (cmd_out),
    .valid_q (cmd_valid),
    .year_q  (year_en),
    .test_q  (test_mode)
  );

  assign feb29_manual = ~year_en;
  assign timer_halt   = ~year_en;
endmodule

// File: rtl/cmd_mode_decoder_chk.sv
module cmd_mode_decoder_chk #(
  parameter int PAR_W = 3,
  parameter int SER_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PAR_W-1:0] par_cmd,
  input logic [SER_W-1:0] ser_cmd,
  input logic             strobe,
  input logic             cs,
  input logic [SER_W-1:0] cmd_out,
  input logic             cmd_valid,
  input logic             year_en,
  input logic             test_mode,
  input logic             feb29_manual,
  input logic             timer_halt
);
  localparam logic [PAR_W-1:0] ESC = '1;
  localparam logic [SER_W-1:0] S1  = '1;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R1
  AST_VALID_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs) && $past(strobe)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(year_en) && $stable(test_mode) && $stable(cmd_out)); // R2
  AST_SER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && $past(par_cmd) == ESC |-> cmd_out == $past(ser_cmd)); // R3
  AST_PAR_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && $past(par_cmd) != ESC |-> cmd_out == SER_W'($past(par_cmd))); // R4
  AST_YEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> year_en == ($past(par_cmd) == ESC)); // R5
  AST_TEST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && $past(par_cmd) == ESC && $past(ser_cmd) == S1 |-> test_mode); // R6
  AST_TEST_PAR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && $past(par_cmd) != ESC |-> !test_mode); // R7
  AST_LEAP_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (feb29_manual == !year_en) && (timer_halt == !year_en)); // R9
endmodule

bind cmd_mode_decoder cmd_mode_decoder_chk #(.PAR_W(PAR_W), .SER_W(SER_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .par_cmd      (par_cmd),
  .ser_cmd      (ser_cmd),
  .strobe       (strobe),
  .cs           (cs),
  .cmd_out      (cmd_out),
  .cmd_valid    (cmd_valid),
  .year_en      (year_en),
  .test_mode    (test_mode),
  .feb29_manual (feb29_manual),
  .timer_halt   (timer_halt)
);

// File: tb/tb_cmd_mode_decoder.sv
module tb_cmd_mode_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] par_cmd = 3'd0;
  logic [3:0] ser_cmd = 4'd0;
  logic       strobe = 1'b0;
  logic       cs = 1'b0;
  logic [3:0] cmd_out;
  logic       cmd_valid, year_en, test_mode, feb29_manual, timer_halt;

  int total = 0;
  int bad = 0;
  logic [3:0] e_cmd = 4'd0;
  logic       e_year = 1'b0;
  logic       e_tm = 1'b0;

  cmd_mode_decoder dut (
    .clk(clk), .rst_n(rst_n), .par_cmd(par_cmd), .ser_cmd(ser_cmd),
    .strobe(strobe), .cs(cs), .cmd_out(cmd_out), .cmd_valid(cmd_valid),
    .year_en(year_en), .test_mode(test_mode), .feb29_manual(feb29_manual),
    .timer_halt(timer_halt)
  );

  always #5 clk = ~clk;

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic next_tm(input logic [2:0] p, input logic [3:0] s, input logic cur);
    if (p != 3'b111) return 1'b0;              // R7
    if (s == 4'hF) return 1'b1;                // R6
    if (s == 4'h0 || (s >= 4'h4 && s <= 4'hE)) return 1'b0; // R8
    return cur;                                // R8 keep codes
  endfunction

  task automatic apply(input logic [2:0] p, input logic [3:0] s, input logic c);
    @(negedge clk);
    par_cmd = p; ser_cmd = s; cs = c; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    if (c) begin
      e_cmd  = (p == 3'b111) ? s : {1'b0, p};
      e_year = (p == 3'b111);
      e_tm   = next_tm(p, s, e_tm);
      chk("R1 valid", {3'b0, cmd_valid}, 4'd1);
      chk(p == 3'b111 ? "R3 cmd" : "R4 cmd", cmd_out, e_cmd);
    end else begin
      chk("R2 valid", {3'b0, cmd_valid}, 4'd0);
      chk("R2 cmd", cmd_out, e_cmd);
    end
    chk("R5 year", {3'b0, year_en}, {3'b0, e_year});
    chk("R6 R7 R8 test", {3'b0, test_mode}, {3'b0, e_tm});
    chk("R9 flags", {2'b0, feb29_manual, timer_halt}, {2'b0, !e_year, !e_year});
    @(negedge clk);
    chk("R1 pulse", {3'b0, cmd_valid}, 4'd0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 cmd", cmd_out, 4'd0);
    chk("R10 valid", {3'b0, cmd_valid}, 4'd0);
    chk("R10 year", {3'b0, year_en}, 4'd0);
    chk("R10 test", {3'b0, test_mode}, 4'd0);
    chk("R10 flags", {2'b0, feb29_manual, timer_halt}, 4'd3);
    apply(3'b101, 4'h9, 1'b1);
    apply(3'b111, 4'h5, 1'b1);
    apply(3'b111, 4'hF, 1'b1);
    for (int k = 1; k <= 3; k++) apply(3'b111, 4'(k), 1'b1);
    apply(3'b010, 4'hF, 1'b0);
    apply(3'b111, 4'h4, 1'b1);
    apply(3'b111, 4'hF, 1'b1);
    apply(3'b111, 4'hE, 1'b1);
    apply(3'b111, 4'hF, 1'b1);
    apply(3'b111, 4'h0, 1'b1);
    apply(3'b111, 4'hF, 1'b1);
    apply(3'b110, 4'hF, 1'b1);
    apply(3'b111, 4'hF, 1'b1);
    apply(3'b000, 4'h3, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [2:0] p;
      logic [3:0] s;
      logic       c;
      p = ($urandom % 2) ? 3'b111 : 3'($urandom % 8);
      s = ($urandom % 4 == 0) ? 4'hF : 4'($urandom % 16);
      c = ($urandom % 5) != 0;
      apply(p, s, c);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule